// File: doc/BRIEF.md
# Single-Pin Clock and Reset Pulse Encoder

This block lets a controller clock and clear a remote counter through one three-state pin. A pin that is released (output enable low) means "nothing". Driven high, it means "clock". Driven low, it means "reset". Callers raise a one-cycle strobe to ask for a clock pulse or a reset pulse. The block turns each request into a sequence on the pin: released, then driven for a fixed number of cycles, then released again. An idle gap always follows each pulse, so the far end never sees a spurious edge.

Requests that arrive while the pin is busy are stored and sent later. When both kinds are waiting, reset is sent first. Repeated requests of one kind that arrive before that kind has started are merged into a single pulse.

A matching decoder sits in the same top module. It turns the pin value and output enable back into separate clock and reset lines, so the whole path can be observed at the ports.

Top module: `tri_pin_pulse_enc`

## Requirements
- R1: While `rst_n` is low and in the first cycle after release, `pin_oe`, `pin_o`, `dec_clk` and `dec_rst` are all 0, and no request is held.
- R2: A clock pulse drives `pin_oe`=1 and `pin_o`=1 for exactly `PULSE_CYC` consecutive cycles.
- R3: A reset pulse drives `pin_oe`=1 and `pin_o`=0 for exactly `PULSE_CYC` consecutive cycles.
- R4: The decoder gives `dec_clk`=`pin_oe`&`pin_o` and `dec_rst`=`pin_oe`&~`pin_o`. With `pin_oe`=0 both are 0, and they are never 1 together.
- R5: A request strobe sampled at a rising edge, while the block is idle with nothing pending, makes `pin_oe` rise after the second rising edge that follows the strobe.
- R6: A request that arrives during a pulse is held and then sent. Between two pulses `pin_oe` stays 0 for at least `GAP_CYC`+1 cycles.
- R7: When both kinds are pending at the moment a pulse can start, the reset pulse is sent first and the clock pulse follows it (default `RST_FIRST`=1).
- R8: Any number of requests of one kind that arrive while that kind is pending and not yet started produce exactly one pulse.
- R9: `pin_o` is 0 whenever `pin_oe` is 0, and it stays constant during a drive phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_req | input | 1 | One-cycle strobe asking for a clock pulse |
| rst_req | input | 1 | One-cycle strobe asking for a reset pulse |
| pin_o | output | 1 | Level driven onto the shared pin |
| pin_oe | output | 1 | Output enable of the shared pin (0 = high impedance) |
| dec_clk | output | 1 | Decoded clock line at the far end |
| dec_rst | output | 1 | Decoded reset line at the far end |

## Verification
The bench builds the block with `PULSE_CYC`=5 and `GAP_CYC`=2, keeping `RST_FIRST` at 1. With these short windows, pulse widths, gap lengths and the exact cycle a queued pulse starts can be checked many hundreds of times. Random strobes then land before a pulse, inside its drive phase, inside the gap and on the starting edge itself. That coverage exercises holding, merging and priority between the two kinds.

// File: rtl/tri_pin_pulse_pkg.sv
package tri_pin_pulse_pkg;
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_DRIVE = 2'd1,
      PH_GAP   = 2'd2
   } phase_t;

   // encoding equals the pin level driven for that kind
   typedef enum logic {
      KIND_RST = 1'b0,
      KIND_CLK = 1'b1
   } kind_t;
endpackage

// File: rtl/tri_pin_req_hold.sv
module tri_pin_req_hold #(
   parameter bit RST_FIRST = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      clk_req,
   input  logic                      rst_req,
   input  logic                      take,
   output logic                      has_work,
   output tri_pin_pulse_pkg::kind_t  next_kind
);
   import tri_pin_pulse_pkg::*;

   logic hold_clk, hold_rst;
   logic take_clk, take_rst;

   generate
      if (RST_FIRST) begin : g_rst_wins
         assign next_kind = hold_rst ? KIND_RST : KIND_CLK;
      end else begin : g_clk_wins
         assign next_kind = hold_clk ? KIND_CLK : KIND_RST;
      end
   endgenerate

   assign has_work = hold_clk | hold_rst;
   assign take_clk = take & (next_kind == KIND_CLK);
   assign take_rst = take & (next_kind == KIND_RST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_clk <= 1'b0;
         hold_rst <= 1'b0;
      end else begin
         hold_clk <= (hold_clk & ~take_clk) | clk_req;
         hold_rst <= (hold_rst & ~take_rst) | rst_req;
      end
   end
endmodule

// File: rtl/tri_pin_phase_seq.sv
module tri_pin_phase_seq #(
   parameter int PULSE_CYC = 1000,
   parameter int GAP_CYC   = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      has_work,
   input  tri_pin_pulse_pkg::kind_t  next_kind,
   output logic                      take,
   output logic                      drive_en,
   output logic                      drive_lvl
);
   import tri_pin_pulse_pkg::*;

   localparam int SPAN  = (PULSE_CYC > GAP_CYC) ? PULSE_CYC : GAP_CYC;
   localparam int CNT_W = (SPAN < 2) ? 1 : $clog2(SPAN);
   localparam logic [CNT_W-1:0] LOAD_DRIVE = CNT_W'(PULSE_CYC - 1);
   localparam logic [CNT_W-1:0] LOAD_GAP   = CNT_W'(GAP_CYC - 1);

   phase_t           phase;
   kind_t            kind_q;
   logic [CNT_W-1:0] left;

   assign take      = (phase == PH_IDLE) & has_work;
   assign drive_en  = (phase == PH_DRIVE);
   assign drive_lvl = drive_en & (kind_q == KIND_CLK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= PH_IDLE;
         kind_q <= KIND_RST;
         left   <= '0;
      end else begin
         unique case (phase)
            PH_IDLE: begin
               if (has_work) begin
                  phase  <= PH_DRIVE;
                  kind_q <= next_kind;
                  left   <= LOAD_DRIVE;
               end
            end
            PH_DRIVE: begin
               if (left == '0) begin
                  phase <= PH_GAP;
                  left  <= LOAD_GAP;
               end else begin
                  left <= left - 1'b1;
               end
            end
            PH_GAP: begin
               if (left == '0) begin
                  phase <= PH_IDLE;
               end else begin
                  left <= left - 1'b1;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/tri_pin_decode.sv
module tri_pin_decode (
   input  logic pin_val,
   input  logic pin_en,
   output logic far_clk,
   output logic far_rst
);
   // released pin reads as idle on both lines
   always_comb begin
      far_clk = 1'b0;
      far_rst = 1'b0;
      if (pin_en) begin
         far_clk = pin_val;
         far_rst = ~pin_val;
      end
   end
endmodule

// File: rtl/tri_pin_pulse_enc.sv
module tri_pin_pulse_enc #(
   parameter int PULSE_CYC = 1000,
   parameter int GAP_CYC   = 2,
   parameter bit RST_FIRST = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clk_req,
   input  logic rst_req,
   output logic pin_o,
   output logic pin_oe,
   output logic dec_clk,
   output logic dec_rst
);
   import tri_pin_pulse_pkg::*;

   generate
      if (PULSE_CYC < 1) begin : g_bad_pulse
         $error("PULSE_CYC must be at least 1");
      end
      if (GAP_CYC < 1) begin : g_bad_gap
         $error("GAP_CYC must be at least 1");
      end
   endgenerate

   logic  has_work;
   logic  take;
   kind_t next_kind;

   tri_pin_req_hold #(.RST_FIRST(RST_FIRST)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .clk_req   (clk_req),
      .rst_req   (rst_req),
      .take      (take),
      .has_work  (has_work),
      .next_kind (next_kind)
   );

   tri_pin_phase_seq #(.PULSE_CYC(PULSE_CYC), .GAP_CYC(GAP_CYC)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .has_work  (has_work),
      .next_kind (next_kind),
      .take      (take),
      .drive_en  (pin_oe),
      .drive_lvl (pin_o)
   );

   tri_pin_decode u_dec (
      .pin_val (pin_o),
      .pin_en  (pin_oe),
      .far_clk (dec_clk),
      .far_rst (dec_rst)
   );
endmodule

// File: rtl/tri_pin_pulse_enc_chk.sv
module tri_pin_pulse_enc_chk #(
   parameter int PULSE_CYC = 1000,
   parameter int GAP_CYC   = 2
) (
   input logic clk,
   input logic rst_n,
   input logic pin_o,
   input logic pin_oe,
   input logic dec_clk,
   input logic dec_rst
);
   logic [31:0] on_run;
   logic [31:0] off_run;
   logic        had_pulse;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         on_run    <= '0;
         off_run   <= '0;
         had_pulse <= 1'b0;
      end else begin
         on_run  <= pin_oe ? on_run + 1 : '0;
         if (pin_oe) off_run <= '0;
         else if (off_run < 32'(GAP_CYC + 1)) off_run <= off_run + 1;
         if (pin_oe) had_pulse <= 1'b1;
      end
   end

   AST_RELEASED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_oe |-> (!dec_clk && !dec_rst)); // R4
   AST_LINES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(dec_clk && dec_rst)); // R4
   AST_DRIVE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pin_oe) |-> (on_run == 32'(PULSE_CYC))); // R2 R3
   AST_GAP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pin_oe) && had_pulse) |-> (off_run >= 32'(GAP_CYC + 1))); // R6
   AST_LEVEL_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_oe |-> !pin_o); // R9
   AST_LEVEL_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_oe && $past(pin_oe)) |-> $stable(pin_o)); // R9
endmodule

bind tri_pin_pulse_enc tri_pin_pulse_enc_chk #(
   .PULSE_CYC (PULSE_CYC),
   .GAP_CYC   (GAP_CYC)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .pin_o   (pin_o),
   .pin_oe  (pin_oe),
   .dec_clk (dec_clk),
   .dec_rst (dec_rst)
);

// File: tb/tb_tri_pin_pulse_enc.sv
module tb_tri_pin_pulse_enc;
   localparam int P = 5;
   localparam int G = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clk_req = 1'b0;
   logic rst_req = 1'b0;
   logic pin_o, pin_oe, dec_clk, dec_rst;

   int total = 0;
   int bad   = 0;
   int cycles = 0;
   bit cmp_en = 1'b0;

   always #5 clk = ~clk;

   tri_pin_pulse_enc #(.PULSE_CYC(P), .GAP_CYC(G), .RST_FIRST(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .clk_req(clk_req), .rst_req(rst_req),
      .pin_o(pin_o), .pin_oe(pin_oe), .dec_clk(dec_clk), .dec_rst(dec_rst)
   );

   // requirement model: 0 idle, 1 drive, 2 gap
   int m_ph = 0;
   int m_left = 0;
   bit m_pc = 0, m_pr = 0, m_kclk = 0;

   function automatic bit exp_oe(int ph);
      return ph == 1;
   endfunction
   function automatic bit exp_lvl(int ph, bit kclk);
      return (ph == 1) && kclk;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_left = 0; m_pc = 0; m_pr = 0; m_kclk = 0;
      end else begin
         bit start, sel_clk;
         start   = (m_ph == 0) && (m_pc || m_pr);
         sel_clk = !m_pr;
         if (m_ph == 0) begin
            if (start) begin m_ph = 1; m_kclk = sel_clk; m_left = P - 1; end
         end else if (m_ph == 1) begin
            if (m_left == 0) begin m_ph = 2; m_left = G - 1; end
            else m_left = m_left - 1;
         end else begin
            if (m_left == 0) m_ph = 0;
            else m_left = m_left - 1;
         end
         m_pc = (m_pc && !(start && sel_clk)) || clk_req;
         m_pr = (m_pr && !(start && !sel_clk)) || rst_req;
      end
   end

   task automatic chk(string tag, logic [3:0] got, logic [3:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got=%b exp=%b at cycle %0d", tag, got, exp, cycles);
      end
   endtask

   always @(negedge clk) begin
      cycles++;
      if (cmp_en && rst_n) begin
         chk("R2 R3 R9 pin", {2'b0, pin_oe, pin_o}, {2'b0, exp_oe(m_ph), exp_lvl(m_ph, m_kclk)});
         chk("R4 decode", {2'b0, dec_clk, dec_rst},
             {2'b0, exp_oe(m_ph) && m_kclk, exp_oe(m_ph) && !m_kclk});
      end
   end

   task automatic step(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic strobe(bit c, bit r);
      clk_req = c; rst_req = r;
      @(negedge clk);
      clk_req = 0; rst_req = 0;
   endtask

   initial begin : watchdog
      wait (cycles > 150000);
      bad++; total++;
      $display("FAIL watchdog: got=expired exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      step(3);
      chk("R1 reset outputs", {pin_oe, pin_o, dec_clk, dec_rst}, 4'b0000);
      rst_n = 1'b1;
      step(1);
      chk("R1 after release", {pin_oe, pin_o, dec_clk, dec_rst}, 4'b0000);
      step(3);
      chk("R1 nothing held", {pin_oe, pin_o, dec_clk, dec_rst}, 4'b0000);
      cmp_en = 1'b1;

      // R5 latency and R2 clock pulse width
      strobe(1, 0);
      chk("R5 not yet driven", {3'b0, pin_oe}, 4'b0000);
      step(1);
      chk("R5 R2 clock start", {pin_oe, pin_o, dec_clk, dec_rst}, 4'b1110);
      step(P - 1);
      chk("R2 last drive cycle", {pin_oe, pin_o, dec_clk, dec_rst}, 4'b1110);
      step(1);
      chk("R2 released after width", {pin_oe, pin_o, dec_clk, dec_rst}, 4'b0000);
      step(G + 4);

      // R3 reset pulse
      strobe(0, 1);
      step(1);
      chk("R3 reset start", {pin_oe, pin_o, dec_clk, dec_rst}, 4'b1001);
      step(P - 1);
      chk("R3 last drive cycle", {pin_oe, pin_o, dec_clk, dec_rst}, 4'b1001);
      step(1);
      chk("R3 released after width", {2'b0, pin_oe, pin_o}, 4'b0000);
      step(G + 4);

      // R7 both at once: reset first, then clock
      strobe(1, 1);
      step(1);
      chk("R7 reset goes first", {pin_oe, pin_o, dec_clk, dec_rst}, 4'b1001);
      step(P + G);
      chk("R7 R6 idle before clock", {3'b0, pin_oe}, 4'b0000);
      step(1);
      chk("R7 clock follows", {pin_oe, pin_o, dec_clk, dec_rst}, 4'b1110);
      step(P + G + 4);

      // R6 request during a pulse is held
      strobe(1, 0);
      step(1);
      rst_req = 1; step(1); rst_req = 0;
      chk("R6 pulse undisturbed", {pin_oe, pin_o, dec_clk, dec_rst}, 4'b1110);
      step(P + G);
      chk("R6 held reset sent", {pin_oe, pin_o, dec_clk, dec_rst}, 4'b1001);
      step(P + G + 4);

      // R8 repeated requests while pending merge into one
      strobe(1, 0);
      step(1);
      clk_req = 1; step(2); clk_req = 0;
      step(P + G - 1);
      chk("R8 one extra clock", {pin_oe, pin_o, dec_clk, dec_rst}, 4'b1110);
      step(P);
      begin
         int extra = 0;
         for (int i = 0; i < 20; i++) begin
            if (pin_oe) extra++;
            step(1);
         end
         chk("R8 no second extra", 4'(extra), 4'd0);
      end

      // random mix, checked every cycle against the model
      for (int i = 0; i < 3000; i++) begin
         clk_req = ($urandom % 8) == 0;
         rst_req = ($urandom % 10) == 0;
         step(1);
      end
      clk_req = 0; rst_req = 0;
      step(40);
      chk("R6 drained to idle", {3'b0, pin_oe}, 4'b0000);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule